// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is a calendar clock that counts wall time from a 32768 Hz tick enable. It holds seconds, minutes, hours, day of month, month, a two-digit year (00 to 99, read as 2000 to 2099) and a day of week. Every field is a packed-BCD byte, and the carry from one field to the next is worked out in BCD. A prescaler counts `TICKS_PER_SEC` tick pulses per second. A small sequencer guards each seconds update with a busy flag, so software can tell when a read of all the fields is coherent.

Software sees every field directly on output ports. It changes state through one byte-wide write port, which presets any time field, sets the run and 12-hour control bits, and clears event flags. Presetting works while the counter runs. Writing the seconds field restarts the prescaler, so a full second elapses before the next increment.

The sequencer has three states:
- `ST_STOP`: the counter is frozen.
- `ST_COUNT`: the prescaler is counting ticks.
- `ST_BUSY`: the last tick period before an update.

Its transitions are:
- **start**: `ST_STOP` goes to `ST_COUNT`, or to `ST_BUSY` when the prescaler is already at its last value.
- **arm**: `ST_COUNT` goes to `ST_BUSY` on the tick that brings the prescaler to its last value.
- **commit**: `ST_BUSY` goes to `ST_COUNT` on the next tick. This tick increments the seconds and clears the prescaler.
- **halt**: any state goes to `ST_STOP` when the run bit is clear.
- **restart**: any state goes to `ST_COUNT` (or to `ST_STOP` if not running) with the prescaler cleared, on a seconds write.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x06. The control byte and the status byte both read 0x00.
- R2: Control bit 0 (write address 8) runs the counter when 1 and freezes every field when 0. Status bit 1 reads 1 exactly while the sequencer is not stopped.
- R3: While running, seconds advance once per `TICKS_PER_SEC` tick pulses and hold otherwise. A write to seconds (address 0) clears the prescaler, so the next increment comes a full `TICKS_PER_SEC` ticks later.
- R4: Status bit 0 (busy) is 1 from the tick that brings the prescaler to its last count until the tick that updates seconds. It is 0 after that update, and it is never 1 while stopped.
- R5: Seconds and minutes count in BCD. The low digit carries from 9 to the next ten, and each field wraps 0x59 to 0x00 with a carry into the next field.
- R6: In 24-hour mode (control bit 3 = 0), hours wrap 0x23 to 0x00 and the day advances.
- R7: In 12-hour mode (control bit 3 = 1), hours bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. 11 goes to 12 and toggles PM. 12 goes to 01 and keeps PM. Only 11 PM going to 12 AM advances the day.
- R8: The day wraps to 0x01 after 0x30 for months 0x04, 0x06, 0x09 and 0x11, and after 0x31 for the other months. On that wrap the month advances. The month wraps 0x12 to 0x01 and advances the year, and the year wraps 0x99 to 0x00.
- R9: February ends after day 0x29 when the year is divisible by 4, otherwise after day 0x28.
- R10: The weekday advances with each day advance and wraps 0x06 to 0x00.
- R11: Status bits 2, 3, 4 and 5 are set when seconds, minutes, hours and day respectively are incremented. Writing 1 to a bit at address 9 clears it, and a set in the same cycle wins over the clear.
- R12: The write port loads fields at addresses 0 to 6 (seconds, minutes, hours, day, month, year, weekday), masked to 7, 7, 6, 6, 5, 8 and 3 bits respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz period |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, bit 5 PM in 12-hour mode |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year within century, BCD |
| wday_o | output | 8 | Day of week, 0 to 6 |
| ctrl_o | output | 8 | Control byte: bit 0 run, bit 3 12-hour |
| status_o | output | 8 | Status byte: busy, running, four event flags |

## Verification
The assertions check on every cycle the properties that tie the sequencer to the port-visible state:
- Busy is only ever seen while running.
- Seconds never move without a committing tick or a write.
- Every commit raises the seconds event.
- Every commit drops busy.

The calendar arithmetic can only be shown by the directed scenarios. This covers BCD digit carries, month lengths, leap February, year wrap, weekday wrap and the 12-hour PM sequence. The scenarios also show the prescaler restart on a seconds write and the exact tick on which busy rises.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam logic [3:0] ADDR_SEC  = 4'd0;
    localparam logic [3:0] ADDR_MIN  = 4'd1;
    localparam logic [3:0] ADDR_HOUR = 4'd2;
    localparam logic [3:0] ADDR_MDAY = 4'd3;
    localparam logic [3:0] ADDR_MON  = 4'd4;
    localparam logic [3:0] ADDR_YEAR = 4'd5;
    localparam logic [3:0] ADDR_WDAY = 4'd6;
    localparam logic [3:0] ADDR_CTRL = 4'd8;
    localparam logic [3:0] ADDR_STAT = 4'd9;

    localparam logic [7:0] MASK_SEC  = 8'h7F;
    localparam logic [7:0] MASK_MIN  = 8'h7F;
    localparam logic [7:0] MASK_HOUR = 8'h3F;
    localparam logic [7:0] MASK_MDAY = 8'h3F;
    localparam logic [7:0] MASK_MON  = 8'h1F;
    localparam logic [7:0] MASK_YEAR = 8'hFF;
    localparam logic [7:0] MASK_WDAY = 8'h07;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] mday;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] wday;
    } cal_t;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_BUSY  = 2'd2
    } seq_state_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] year);
        logic [7:0] ybin;
        logic [7:0] r;
        ybin = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        if (mon == 8'h02)
            r = (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
        else if (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11)
            r = 8'h30;
        else
            r = 8'h31;
        return r;
    endfunction

endpackage

// File: rtl/bcd_cal_seq.sv
module bcd_cal_seq
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic presc_clr,
    output logic sec_pulse,
    output logic busy,
    output logic running
);

    localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST     = PW'(TICKS_PER_SEC - 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 2);

    seq_state_t    st, st_n;
    logic [PW-1:0] presc, presc_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_STOP;
            presc <= '0;
        end else begin
            st    <= st_n;
            presc <= presc_n;
        end
    end

    always_comb begin
        st_n    = st;
        presc_n = presc;
        if (presc_clr) begin
            presc_n = '0;
            st_n    = run ? ST_COUNT : ST_STOP;
        end else begin
            unique case (st)
                ST_STOP: begin
                    if (run) st_n = (presc == LAST) ? ST_BUSY : ST_COUNT;
                end
                ST_COUNT: begin
                    if (!run) begin
                        st_n = ST_STOP;
                    end else if (tick_en) begin
                        presc_n = presc + 1'b1;
                        if (presc == PRE_LAST) st_n = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (!run) begin
                        st_n = ST_STOP;
                    end else if (tick_en) begin
                        presc_n = '0;
                        st_n    = ST_COUNT;
                    end
                end
                default: st_n = ST_STOP;
            endcase
        end
    end

    always_comb begin
        busy      = (st == ST_BUSY);
        running   = (st != ST_STOP);
        sec_pulse = (st == ST_BUSY) && run && tick_en && !presc_clr;
    end

endmodule

// File: rtl/bcd_cal_next.sv
module bcd_cal_next
    import bcd_cal_pkg::*;
(
    input  cal_t cur,
    input  logic mode12,
    output cal_t nxt,
    output logic ev_min,
    output logic ev_hour,
    output logic ev_day
);

    logic [7:0] h_inc;
    logic [7:0] last_day;

    always_comb begin
        nxt      = cur;
        ev_min   = 1'b0;
        ev_hour  = 1'b0;
        ev_day   = 1'b0;
        h_inc    = bcd_inc({3'b000, cur.hour[4:0]});
        last_day = month_last_day(cur.mon, cur.year);

        if (cur.sec >= 8'h59) begin
            nxt.sec = 8'h00;
            ev_min  = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end

        if (ev_min) begin
            if (cur.min >= 8'h59) begin
                nxt.min = 8'h00;
                ev_hour = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        if (ev_hour) begin
            if (mode12) begin
                if (cur.hour[4:0] == 5'h12) begin
                    nxt.hour = {2'b00, cur.hour[5], 5'h01};
                end else if (cur.hour[4:0] == 5'h11) begin
                    nxt.hour = {2'b00, ~cur.hour[5], 5'h12};
                    ev_day   = cur.hour[5];
                end else begin
                    nxt.hour = {2'b00, cur.hour[5], h_inc[4:0]};
                end
            end else if (cur.hour >= 8'h23) begin
                nxt.hour = 8'h00;
                ev_day   = 1'b1;
            end else begin
                nxt.hour = bcd_inc(cur.hour);
            end
        end

        if (ev_day) begin
            nxt.wday = (cur.wday >= 8'h06) ? 8'h00 : cur.wday + 8'h01;
            if (cur.mday >= last_day) begin
                nxt.mday = 8'h01;
                if (cur.mon >= 8'h12) begin
                    nxt.mon  = 8'h01;
                    nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
                end else begin
                    nxt.mon = bcd_inc(cur.mon);
                end
            end else begin
                nxt.mday = bcd_inc(cur.mday);
            end
        end
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic [7:0] wday_o,
    output logic [7:0] ctrl_o,
    output logic [7:0] status_o
);

    localparam cal_t RESET_CAL = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   mday: 8'h01, mon: 8'h01, year: 8'h00,
                                   wday: 8'h06};

    cal_t       cal_q, cal_nxt;
    logic       run_q, mode12_q;
    logic [3:0] ev_q, ev_set, ev_clr;
    logic       sec_pulse, busy, running;
    logic       ev_min, ev_hour, ev_day;
    logic       sec_wr;

    assign sec_wr = wr_en && (wr_addr == ADDR_SEC);

    bcd_cal_seq #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (run_q),
        .presc_clr (sec_wr),
        .sec_pulse (sec_pulse),
        .busy      (busy),
        .running   (running)
    );

    bcd_cal_next u_next (
        .cur     (cal_q),
        .mode12  (mode12_q),
        .nxt     (cal_nxt),
        .ev_min  (ev_min),
        .ev_hour (ev_hour),
        .ev_day  (ev_day)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= RESET_CAL;
        end else begin
            if (sec_pulse) cal_q <= cal_nxt;
            if (wr_en) begin
                unique case (wr_addr)
                    ADDR_SEC:  cal_q.sec  <= wr_data & MASK_SEC;
                    ADDR_MIN:  cal_q.min  <= wr_data & MASK_MIN;
                    ADDR_HOUR: cal_q.hour <= wr_data & MASK_HOUR;
                    ADDR_MDAY: cal_q.mday <= wr_data & MASK_MDAY;
                    ADDR_MON:  cal_q.mon  <= wr_data & MASK_MON;
                    ADDR_YEAR: cal_q.year <= wr_data & MASK_YEAR;
                    ADDR_WDAY: cal_q.wday <= wr_data & MASK_WDAY;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode12_q <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            run_q    <= wr_data[0];
            mode12_q <= wr_data[3];
        end
    end

    always_comb begin
        ev_set = {sec_pulse && ev_day, sec_pulse && ev_hour,
                  sec_pulse && ev_min, sec_pulse};
        ev_clr = (wr_en && wr_addr == ADDR_STAT) ? wr_data[5:2] : 4'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= 4'd0;
        else        ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    always_comb begin
        sec_o    = cal_q.sec;
        min_o    = cal_q.min;
        hour_o   = cal_q.hour;
        mday_o   = cal_q.mday;
        mon_o    = cal_q.mon;
        year_o   = cal_q.year;
        wday_o   = cal_q.wday;
        ctrl_o   = {4'd0, mode12_q, 2'd0, run_q};
        status_o = {2'd0, ev_q, running, busy};
    end

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_en,
    input logic [7:0] sec_o,
    input logic [7:0] ctrl_o,
    input logic [7:0] status_o
);

    // R4: busy is only ever seen while the sequencer is running
    a_r4_busy_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> status_o[1]);

    // R3: seconds hold unless a committing tick or a write occurs
    a_r3_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(status_o[0] && tick_en)) |=> $stable(sec_o));

    // R11: a commit sets the seconds event flag
    a_r11_sec_event: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && ctrl_o[0] && tick_en && !wr_en) |=> status_o[2]);

    // R4: busy falls on the commit tick
    a_r4_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && ctrl_o[0] && tick_en && !wr_en) |=> !status_o[0]);

endmodule

bind bcd_calendar bcd_calendar_chk u_chk (.*);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, mday_o, mon_o, year_o, wday_o, ctrl_o, status_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
        .wday_o(wday_o), .ctrl_o(ctrl_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic set_cal(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                           input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s);
        wr(4'd5, y); wr(4'd4, mo); wr(4'd3, d);
        wr(4'd2, h); wr(4'd1, mi); wr(4'd0, s);
    endtask

    task automatic t_reset;
        chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00); chk("R1 mday", mday_o, 8'h01);
        chk("R1 mon", mon_o, 8'h01);   chk("R1 year", year_o, 8'h00);
        chk("R1 wday", wday_o, 8'h06); chk("R1 ctrl", ctrl_o, 8'h00);
        chk("R1 status", status_o, 8'h00);
    endtask

    task automatic t_stopped_hold;
        tick(8);
        chk("R2 frozen sec", sec_o, 8'h00);
        chk("R2 not running", status_o, 8'h00);
    endtask

    task automatic t_run_busy;
        wr(4'd8, 8'h01);
        chk("R2 ctrl run", ctrl_o, 8'h01);
        chk("R2 running", status_o, 8'h02);
        tick(TPS - 1);
        chk("R4 busy high", status_o, 8'h03);
        chk("R3 no early inc", sec_o, 8'h00);
        tick(1);
        chk("R3 one second", sec_o, 8'h01);
        chk("R4 busy low R11 sec event", status_o, 8'h06);
        wr(4'd9, 8'h04);
        chk("R11 w1c", status_o, 8'h02);
    endtask

    task automatic t_presc_restart;
        tick(2);
        wr(4'd0, 8'h20);
        tick(TPS - 1);
        chk("R3 restart hold", sec_o, 8'h20);
        tick(1);
        chk("R3 restart inc", sec_o, 8'h21);
        wr(4'd9, 8'h3C);
    endtask

    task automatic t_bcd_digits;
        wr(4'd0, 8'h09); tick(TPS);
        chk("R5 digit carry", sec_o, 8'h10);
        wr(4'd1, 8'h09); wr(4'd0, 8'h59); tick(TPS);
        chk("R5 sec wrap", sec_o, 8'h00);
        chk("R5 min carry", min_o, 8'h10);
        chk("R11 sec+min events", status_o, 8'h0E);
        wr(4'd9, 8'h3C);
    endtask

    task automatic t_day_24;
        wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R6 hour wrap", hour_o, 8'h00);
        chk("R6 day adv", mday_o, 8'h02);
        chk("R10 wday wrap", wday_o, 8'h00);
        chk("R11 all events", status_o, 8'h3E);
        wr(4'd9, 8'h3C);
        chk("R11 cleared", status_o, 8'h02);
    endtask

    task automatic t_months;
        set_cal(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick(TPS);
        chk("R9 leap 29", mday_o, 8'h29); chk("R9 leap mon", mon_o, 8'h02);
        wr(4'd2, 8'h23); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R9 leap end", mday_o, 8'h01); chk("R9 march", mon_o, 8'h03);
        set_cal(8'h01, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick(TPS);
        chk("R9 nonleap day", mday_o, 8'h01); chk("R9 nonleap mon", mon_o, 8'h03);
        set_cal(8'h05, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); tick(TPS);
        chk("R8 30day day", mday_o, 8'h01); chk("R8 30day mon", mon_o, 8'h05);
        set_cal(8'h05, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); tick(TPS);
        chk("R8 31day", mday_o, 8'h31);
        wr(4'd6, 8'h06);
        set_cal(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59); tick(TPS);
        chk("R8 year wrap", year_o, 8'h00); chk("R8 month wrap", mon_o, 8'h01);
        chk("R8 day wrap", mday_o, 8'h01); chk("R10 wday", wday_o, 8'h00);
        wr(4'd9, 8'h3C);
    endtask

    task automatic t_12h;
        wr(4'd8, 8'h09);
        chk("R7 ctrl", ctrl_o, 8'h09);
        wr(4'd3, 8'h05);
        wr(4'd2, 8'h11); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R7 noon", hour_o, 8'h32); chk("R7 no day at noon", mday_o, 8'h05);
        wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R7 12 to 1 PM", hour_o, 8'h21);
        wr(4'd2, 8'h31); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R7 midnight", hour_o, 8'h12); chk("R7 day adv", mday_o, 8'h06);
        wr(4'd2, 8'h09); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick(TPS);
        chk("R7 AM digit", hour_o, 8'h10);
        wr(4'd9, 8'h3C);
    endtask

    task automatic t_mask_stop;
        wr(4'd6, 8'hFF); chk("R12 wday mask", wday_o, 8'h07);
        wr(4'd2, 8'hFF); chk("R12 hour mask", hour_o, 8'h3F);
        wr(4'd4, 8'hFF); chk("R12 mon mask", mon_o, 8'h1F);
        wr(4'd8, 8'h00);
        chk("R2 stopped", status_o, 8'h00);
        wr(4'd0, 8'h33); tick(3 * TPS);
        chk("R2 stop hold", sec_o, 8'h33);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped_hold();
        t_run_busy();
        t_presc_restart();
        t_bcd_digits();
        t_day_24();
        t_months();
        t_12h();
        t_mask_stop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule